// File: doc/BRIEF.md
# Audio Link Frame Transmitter

This block is the controller-side transmitter of a serial audio link. It runs on the 12.288 MHz bit clock. Every 256 bit clocks it builds one outgoing frame, raises the frame-start strobe, and shifts the frame out MSB first on the serial data line. Data changes on rising edges, so the codec can sample it on falling edges.

Each frame holds five things:
- a 16-bit tag slot;
- a control-address slot;
- a control-data slot;
- two PCM playback slots;
- eight slots that are always zero.

The tag bits declare which slots carry valid content. A pending register access and the two playback samples are captured once per frame, in the last bit clock of the previous frame. Each item that goes into a frame is acknowledged with a one-cycle pulse.

The codec can tell the controller to hold back a channel. It does this with a per-channel hold flag, which supports variable-rate playback. A held channel gets no tag bit, an all-zero slot and no acknowledge, so the caller keeps its sample for a later frame.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame lasts exactly 256 clocks. `sync_o` rises once per frame. The first tag bit (frame valid) appears on `sdo` in the clock that follows the clock in which `sync_o` rose.
- R2: `sync_o` stays high for exactly 16 consecutive clocks per frame: the rise clock plus the first 15 tag bit clocks. It is low for the other 240 clocks.
- R3: Tag slot bits, sent MSB first:
  - bit 15 is frame valid;
  - bit 14 is set for any register access;
  - bit 13 is set for a write access only;
  - bit 12 marks a valid left sample;
  - bit 11 marks a valid right sample;
  - bits 10:0 are zero.
- R4: Frame valid (tag bit 15) is 1 exactly when at least one of tag bits 14 to 11 is 1. A frame with no content is all zeros.
- R5: Slot 1, 20 bits:
  - bit 19 is the operation (1 = write, 0 = read);
  - bits 18:12 are the 7-bit register address;
  - bits 11:0 are zero.
  The whole slot is zero when there is no access.
- R6: Slot 2 carries the 16-bit write data in bits 19:4, with bits 3:0 zero. It is all zero on a read or when there is no access.
- R7: Slots 3 (left) and 4 (right) carry the 18-bit sample in bits 19:2, MSB first, with bits 1:0 zero. Slots 5 to 12 are always zero.
- R8: A channel whose hold input is 1 at capture time has its tag bit clear, its slot all zero and no acknowledge, even when its sample is valid.
- R9: Inputs are captured only in the last clock of the previous frame; changes at any other time do not affect the frame being sent. `ctl_ack`, `pcm_l_ack` and `pcm_r_ack` pulse high for one clock, in the first bit clock of the frame that carries the item.
- R10: During reset, `sync_o`, `sdo` and all acknowledges are 0. The first clock edge after reset is released raises `sync_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctl_req | input | 1 | Register access pending |
| ctl_wr | input | 1 | 1 = write access, 0 = read access |
| ctl_addr | input | 7 | Register address |
| ctl_wdata | input | 16 | Register write data |
| ctl_ack | output | 1 | One-clock pulse when the access is sent |
| pcm_l | input | SAMPLE_W | Left playback sample |
| pcm_l_vld | input | 1 | Left sample available |
| pcm_l_ack | output | 1 | One-clock pulse when the left sample is sent |
| pcm_r | input | SAMPLE_W | Right playback sample |
| pcm_r_vld | input | 1 | Right sample available |
| pcm_r_ack | output | 1 | One-clock pulse when the right sample is sent |
| hold_l | input | 1 | Codec asks not to send a left sample |
| hold_r | input | 1 | Codec asks not to send a right sample |
| sync_o | output | 1 | Frame start strobe |
| sdo | output | 1 | Serial frame data, MSB first |

## Verification
The assertions assume two things about the inputs:
- `ctl_req`, `pcm_l_vld`, `pcm_r_vld` and the hold flags are well defined in the capture clock.
- An acknowledge can only follow a valid flag that was present in that same capture clock.

The stimulus keeps within these assumptions by changing inputs only on falling edges. It sets each frame's inputs in the clock where `sync_o` has just risen, which is the capture clock. The single deliberate change mid-frame checks that inputs are ignored outside the capture clock.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int N_SLOTS = 12;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic ctl_addr;
    logic ctl_data;
    logic pcm_l;
    logic pcm_r;
  } tag_flags_t;

  function automatic logic [TAG_W-1:0] make_tag(input tag_flags_t f);
    return {(|f), f, {(TAG_W-5){1'b0}}};
  endfunction

  function automatic logic [SLOT_W-1:0] make_addr_slot(input logic req, input logic wr,
                                                       input logic [ADDR_W-1:0] addr);
    return req ? {wr, addr, {(SLOT_W-1-ADDR_W){1'b0}}} : '0;
  endfunction

  function automatic logic [SLOT_W-1:0] make_data_slot(input logic wen,
                                                       input logic [DATA_W-1:0] d);
    return wen ? {d, {(SLOT_W-DATA_W){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/aclink_tx_timer.sv
module aclink_tx_timer
  import aclink_tx_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W,
  parameter int SYNC_BITS  = TAG_W
) (
  input  logic clk,
  input  logic rst,
  output logic load_o,
  output logic first_o,
  output logic sync_o
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          sync_q;

  always_comb cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= CW'(FRAME_BITS - 2);
      sync_q <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      sync_q <= (cnt_nxt == LAST) || (cnt_nxt < CW'(SYNC_BITS - 1));
    end
  end

  assign load_o  = (cnt == LAST);
  assign first_o = (cnt == '0);
  assign sync_o  = sync_q;
endmodule

// File: rtl/aclink_tx_assemble.sv
module aclink_tx_assemble
  import aclink_tx_pkg::*;
#(
  parameter int SAMPLE_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                ctl_req,
  input  logic                ctl_wr,
  input  logic [ADDR_W-1:0]   ctl_addr,
  input  logic [DATA_W-1:0]   ctl_wdata,
  input  logic [SAMPLE_W-1:0] pcm_l,
  input  logic                pcm_l_vld,
  input  logic [SAMPLE_W-1:0] pcm_r,
  input  logic                pcm_r_vld,
  input  logic                hold_l,
  input  logic                hold_r,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [TAG_W-1:0]    tag_q_o,
  output logic                ctl_ack,
  output logic                pcm_l_ack,
  output logic                pcm_r_ack
);
  localparam int PAD = SLOT_W - SAMPLE_W;

  tag_flags_t        flags;
  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] s_addr, s_data, s_left, s_right;

  always_comb begin
    flags.ctl_addr = ctl_req;
    flags.ctl_data = ctl_req & ctl_wr;
    flags.pcm_l    = pcm_l_vld & ~hold_l;
    flags.pcm_r    = pcm_r_vld & ~hold_r;
    tag     = make_tag(flags);
    s_addr  = make_addr_slot(ctl_req, ctl_wr, ctl_addr);
    s_data  = make_data_slot(flags.ctl_data, ctl_wdata);
    s_left  = flags.pcm_l ? (SLOT_W'(pcm_l) << PAD) : '0;
    s_right = flags.pcm_r ? (SLOT_W'(pcm_r) << PAD) : '0;
  end

  assign frame_o[FRAME_W-1 -: TAG_W] = tag;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    localparam int HI = FRAME_W - TAG_W - k * SLOT_W - 1;
    if (k == 0) begin : g_addr
      assign frame_o[HI -: SLOT_W] = s_addr;
    end else if (k == 1) begin : g_data
      assign frame_o[HI -: SLOT_W] = s_data;
    end else if (k == 2) begin : g_left
      assign frame_o[HI -: SLOT_W] = s_left;
    end else if (k == 3) begin : g_right
      assign frame_o[HI -: SLOT_W] = s_right;
    end else begin : g_zero
      assign frame_o[HI -: SLOT_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q_o   <= '0;
      ctl_ack   <= 1'b0;
      pcm_l_ack <= 1'b0;
      pcm_r_ack <= 1'b0;
    end else begin
      ctl_ack   <= load & flags.ctl_addr;
      pcm_l_ack <= load & flags.pcm_l;
      pcm_r_ack <= load & flags.pcm_r;
      if (load) tag_q_o <= tag;
    end
  end
endmodule

// File: rtl/aclink_tx_shifter.sv
module aclink_tx_shifter #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] frame_i,
  output logic             sdo
);
  logic [WIDTH-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= frame_i;
    else           shreg <= {shreg[WIDTH-2:0], 1'b0};
  end

  assign sdo = shreg[WIDTH-1];
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int SAMPLE_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_req,
  input  logic                ctl_wr,
  input  logic [ADDR_W-1:0]   ctl_addr,
  input  logic [DATA_W-1:0]   ctl_wdata,
  output logic                ctl_ack,
  input  logic [SAMPLE_W-1:0] pcm_l,
  input  logic                pcm_l_vld,
  output logic                pcm_l_ack,
  input  logic [SAMPLE_W-1:0] pcm_r,
  input  logic                pcm_r_vld,
  output logic                pcm_r_ack,
  input  logic                hold_l,
  input  logic                hold_r,
  output logic                sync_o,
  output logic                sdo
);
  logic               frame_load;
  logic               frame_first;
  logic [FRAME_W-1:0] frame_bits;
  logic [TAG_W-1:0]   tag_q;

  aclink_tx_timer #(.FRAME_BITS(FRAME_W), .SYNC_BITS(TAG_W)) u_timer (
    .clk(clk), .rst(rst), .load_o(frame_load), .first_o(frame_first), .sync_o(sync_o)
  );

  aclink_tx_assemble #(.SAMPLE_W(SAMPLE_W)) u_asm (
    .clk(clk), .rst(rst), .load(frame_load),
    .ctl_req(ctl_req), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .pcm_l(pcm_l), .pcm_l_vld(pcm_l_vld), .pcm_r(pcm_r), .pcm_r_vld(pcm_r_vld),
    .hold_l(hold_l), .hold_r(hold_r),
    .frame_o(frame_bits), .tag_q_o(tag_q),
    .ctl_ack(ctl_ack), .pcm_l_ack(pcm_l_ack), .pcm_r_ack(pcm_r_ack)
  );

  aclink_tx_shifter #(.WIDTH(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(frame_load), .frame_i(frame_bits), .sdo(sdo)
  );
endmodule

// File: rtl/aclink_tx_checker.sv
module aclink_tx_checker
  import aclink_tx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sync_o,
  input logic             sdo,
  input logic             frame_first,
  input logic [TAG_W-1:0] tag_q,
  input logic             ctl_ack,
  input logic             pcm_l_ack,
  input logic             pcm_r_ack,
  input logic             pcm_l_vld,
  input logic             pcm_r_vld,
  input logic             hold_l,
  input logic             hold_r
);
  logic [CNT_W-1:0] sync_run;

  always_ff @(posedge clk) begin
    if (rst)         sync_run <= '0;
    else if (sync_o) sync_run <= sync_run + 1'b1;
    else             sync_run <= '0;
  end

  p_sync_lead_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |=> frame_first);

  p_sync_width_r2: assert property (@(posedge clk) disable iff (rst)
    sync_run <= CNT_W'(TAG_W));

  p_sync_first_r2: assert property (@(posedge clk) disable iff (rst)
    frame_first |-> sync_o);

  p_frame_valid_r4: assert property (@(posedge clk) disable iff (rst)
    frame_first |-> (sdo == (|tag_q[TAG_W-2 -: 4])));

  p_hold_left_r8: assert property (@(posedge clk) disable iff (rst)
    frame_first && $past(hold_l) |-> !pcm_l_ack);

  p_hold_right_r8: assert property (@(posedge clk) disable iff (rst)
    frame_first && $past(hold_r) |-> !pcm_r_ack);

  p_ack_slot_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_ack || pcm_l_ack || pcm_r_ack) |-> frame_first);

  p_ack_source_r9: assert property (@(posedge clk) disable iff (rst)
    (pcm_l_ack |-> $past(pcm_l_vld)) and (pcm_r_ack |-> $past(pcm_r_vld)));
endmodule

bind aclink_tx_framer aclink_tx_checker u_chk (
  .clk(clk), .rst(rst), .sync_o(sync_o), .sdo(sdo), .frame_first(frame_first),
  .tag_q(tag_q), .ctl_ack(ctl_ack), .pcm_l_ack(pcm_l_ack), .pcm_r_ack(pcm_r_ack),
  .pcm_l_vld(pcm_l_vld), .pcm_r_vld(pcm_r_vld), .hold_l(hold_l), .hold_r(hold_r)
);

// File: tb/test_aclink_tx_framer.sv
module test_aclink_tx_framer;
  logic clk = 1'b0;
  logic rst;
  logic ctl_req, ctl_wr, ctl_ack;
  logic [6:0]  ctl_addr;
  logic [15:0] ctl_wdata;
  logic [17:0] pcm_l, pcm_r;
  logic pcm_l_vld, pcm_r_vld, pcm_l_ack, pcm_r_ack, hold_l, hold_r;
  logic sync_o, sdo;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aclink_tx_framer #(.SAMPLE_W(18)) i_aclink_tx_framer (
    .clk(clk), .rst(rst),
    .ctl_req(ctl_req), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ctl_ack(ctl_ack),
    .pcm_l(pcm_l), .pcm_l_vld(pcm_l_vld), .pcm_l_ack(pcm_l_ack),
    .pcm_r(pcm_r), .pcm_r_vld(pcm_r_vld), .pcm_r_ack(pcm_r_ack),
    .hold_l(hold_l), .hold_r(hold_r), .sync_o(sync_o), .sdo(sdo)
  );

  typedef struct packed {
    logic        req;
    logic        wr;
    logic [6:0]  addr;
    logic [15:0] wdata;
    logic        lv;
    logic [17:0] l;
    logic        rv;
    logic [17:0] r;
    logic        hl;
    logic        hr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 7'h00, 16'h0000, 1'b0, 18'h00000, 1'b0, 18'h00000, 1'b0, 1'b0},
    '{1'b1, 1'b1, 7'h02, 16'hA5C3, 1'b1, 18'h3FFFF, 1'b1, 18'h00001, 1'b0, 1'b0},
    '{1'b1, 1'b0, 7'h7F, 16'hBEEF, 1'b0, 18'h12345, 1'b0, 18'h0ABCD, 1'b0, 1'b0},
    '{1'b0, 1'b0, 7'h11, 16'h1111, 1'b1, 18'h2AAAA, 1'b1, 18'h15555, 1'b0, 1'b1},
    '{1'b1, 1'b1, 7'h26, 16'hFFFF, 1'b1, 18'h0F0F0, 1'b1, 18'h30303, 1'b1, 1'b1},
    '{1'b0, 1'b1, 7'h55, 16'h5555, 1'b0, 18'h3FFFF, 1'b1, 18'h20000, 1'b1, 1'b0},
    '{1'b1, 1'b0, 7'h00, 16'h0000, 1'b1, 18'h00001, 1'b1, 18'h3FFFF, 1'b0, 1'b0}
  };

  task automatic chk(input string rq, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Starts at the falling edge in which sync_o has just risen (capture clock).
  task automatic run_frame(input vec_t v, input bit mutate);
    logic [255:0] cap;
    logic [19:0]  e_tag, e_s1, e_s2, e_s3, e_s4;
    logic         send_l, send_r;
    int           sync_bad;
    ctl_req = v.req; ctl_wr = v.wr; ctl_addr = v.addr; ctl_wdata = v.wdata;
    pcm_l_vld = v.lv; pcm_l = v.l; pcm_r_vld = v.rv; pcm_r = v.r;
    hold_l = v.hl; hold_r = v.hr;
    send_l = v.lv && !v.hl;
    send_r = v.rv && !v.hr;
    sync_bad = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      cap[255-i] = sdo;
      if (sync_o !== ((i < 15) || (i == 255))) sync_bad++;
      if (i == 0) begin
        chk("R9 ctl_ack", 20'(ctl_ack), 20'(v.req));
        chk("R8 pcm_l_ack", 20'(pcm_l_ack), 20'(send_l));
        chk("R8 pcm_r_ack", 20'(pcm_r_ack), 20'(send_r));
      end
      if (i == 1) chk("R9 ack one-cycle", 20'({ctl_ack, pcm_l_ack, pcm_r_ack}), 20'd0);
      if (mutate && i == 100) begin
        pcm_l = ~pcm_l; ctl_addr = ~ctl_addr; hold_r = 1'b1; ctl_wr = ~ctl_wr;
      end
    end
    e_tag = 20'd0;
    if (v.req)          e_tag[14] = 1'b1;
    if (v.req && v.wr)  e_tag[13] = 1'b1;
    if (send_l)         e_tag[12] = 1'b1;
    if (send_r)         e_tag[11] = 1'b1;
    if (e_tag != 20'd0) e_tag[15] = 1'b1;
    e_s1 = v.req ? ((20'(v.wr) << 19) | (20'(v.addr) << 12)) : 20'd0;
    e_s2 = (v.req && v.wr) ? (20'(v.wdata) << 4) : 20'd0;
    e_s3 = send_l ? (20'(v.l) << 2) : 20'd0;
    e_s4 = send_r ? (20'(v.r) << 2) : 20'd0;
    chk("R3/R4 tag slot", 20'(cap[255:240]), e_tag);
    chk("R5 slot1", cap[239:220], e_s1);
    chk("R6 slot2", cap[219:200], e_s2);
    chk("R7 slot3", cap[199:180], e_s3);
    chk("R7 slot4", cap[179:160], e_s4);
    chk("R7 slots5-12 zero", 20'(|cap[159:0]), 20'd0);
    chk("R1/R2 sync pattern", 20'(sync_bad), 20'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst = 1'b1;
    ctl_req = 0; ctl_wr = 0; ctl_addr = '0; ctl_wdata = '0;
    pcm_l = '0; pcm_r = '0; pcm_l_vld = 0; pcm_r_vld = 0; hold_l = 0; hold_r = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", 20'({sync_o, sdo, ctl_ack, pcm_l_ack, pcm_r_ack}), 20'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 first sync after reset", 20'(sync_o), 20'd1);

    for (int n = 0; n < NV; n++) run_frame(VECS[n], n == NV - 1);

    // Reset in the middle of a frame.
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid-frame reset", 20'({sync_o, sdo, ctl_ack, pcm_l_ack, pcm_r_ack}), 20'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 sync after second reset", 20'(sync_o), 20'd1);
    run_frame(VECS[1], 1'b0);
    run_frame(VECS[0], 1'b0);
    summary();
  end
endmodule